// File: doc/BRIEF.md
# Dual-Line Flash Read Controller with Instruction Skipping

This block is the host side of a serial flash read that moves address, mode byte and data two bits per serial clock over two data lines. A one-cycle `start` pulse launches a transaction. The controller lowers chip select and sends the 8-bit instruction on line 0 alone. It then sends the address and a mode byte on both lines and releases the lines for a programmable number of dummy clocks. After that it collects the requested number of bytes, presenting each with a one-cycle valid strobe and the address it came from.

The controller remembers whether the previous transaction sent the continuation mode byte (A0h). If it did, the next transaction leaves out the instruction and begins directly with the address. A transaction that sends the terminating mode byte (00h) clears that memory, so the following read sends the instruction again. Each serial-clock slot takes two system clocks, with `sck` low in the first and high in the second. Read data is sampled at the rising edge of `sck`.

The controller is built around one state machine with seven states:
- `ST_IDLE`: waits for `start`.
- `ST_CMD`: sends the instruction.
- `ST_ADDR`: sends the address.
- `ST_MODE`: sends the mode byte.
- `ST_DUMMY`: holds the released lines for the latency period.
- `ST_DATA`: receives the data bytes.
- `ST_STOP`: holds chip select high for one cycle and pulses `done`.

Its transitions are:
- IDLE→CMD: start with no continuation stored.
- IDLE→ADDR: start with continuation stored.
- CMD→ADDR, ADDR→MODE: at the end of each phase.
- MODE→DUMMY: latency code non-zero.
- MODE→DATA: latency zero and byte count non-zero.
- MODE→STOP: latency and byte count both zero.
- DUMMY→DATA: byte count non-zero.
- DUMMY→STOP: byte count zero.
- DATA→STOP: after the last byte.
- STOP→IDLE: unconditional.

Top module: `dio_read_ctrl`

## Requirements
- R1: After reset, `cs_n`=1, `sck`=0, `io_oe`=00, `busy`=0, `done`=0 and `rd_valid`=0.
- R2: A transaction that sends the instruction spends its first 8 slots sending it on `io_out[0]`, MSB first, with `io_oe`=01. The instruction is BBh when `op_sel`=0 and BCh when `op_sel`=1.
- R3: The address follows, MSB first, two bits per slot with `io_oe`=11. `io_out[1]` carries the higher bit of each pair. It takes 12 slots (3 bytes) when `op_sel`=0 and `addr4`=0, and 16 slots (4 bytes) otherwise.
- R4: The mode byte follows the address over 4 slots in the same bit order. It is A0h when `keep_cont`=1 and 00h when `keep_cont`=0.
- R5: The first transaction after reset sends the instruction. A transaction that follows one whose mode byte was A0h sends no instruction and begins with the address. A transaction that follows one whose mode byte was 00h sends the instruction again.
- R6: After the mode byte, the controller spends `lat` dummy slots with `io_oe`=00. From the dummy phase onward the lines stay released until `cs_n` returns high. With `lat`=0 there are no dummy slots.
- R7: Data phase:
  - `io_in` is sampled at each rising edge of `sck`, four slots per byte.
  - The first pair is the byte's top two bits, and `io_in[1]` is the higher bit of each pair.
  - `rd_valid` is high for exactly one cycle, the `sck`-high cycle of the byte's fourth slot, with the byte on `rd_data`.
- R8: `rd_addr` gives each byte's address. It starts at the given address, truncated to 24 bits in 3-byte mode, and rises by one per byte. It wraps to zero after FFFFFFh in 3-byte mode and after FFFFFFFFh in 4-byte mode.
- R9: Every slot is two system clocks, the first with `sck`=0 and the second with `sck`=1. `sck` stays 0 whenever `cs_n`=1.
- R10: After the last slot, `cs_n` is high for one cycle with `done`=1 and `busy`=1, then `busy`=0. With `nbytes`=0 the transaction ends right after the dummy phase and produces no byte.
- R11: A `start` pulse while `busy`=1 has no effect on the running transaction or on its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a read (one-cycle pulse, taken only when idle) |
| addr | input | 32 | Start address |
| addr4 | input | 1 | Four-byte address mode for opcode BBh |
| op_sel | input | 1 | 0 selects opcode BBh, 1 selects BCh |
| lat | input | 4 | Number of dummy slots |
| nbytes | input | 16 | Number of bytes to read |
| keep_cont | input | 1 | Send A0h mode byte to keep continuous mode |
| io_in | input | 2 | Data lines as seen from the flash |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 2 | Values driven onto the data lines |
| io_oe | output | 2 | Per-line drive enable |
| rd_data | output | 8 | Received byte |
| rd_addr | output | 32 | Address of the received byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data`/`rd_addr` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The bench chains transactions so the continuation flag is exercised in both directions:
- A read after an A0h mode byte must drop the instruction.
- A read after 00h must restore it.

A controller that tracked the flag wrongly would shift every later slot by eight and mismatch from the first address slot onward. Starting addresses sit just below the 24-bit and 32-bit tops, so a wrong wrap shows up as a stray upper byte in `rd_addr`.

Zero latency and a zero byte count test the skip paths, where an off-by-one would add or lose a slot or emit a phantom byte. The longest latency is also covered. A `start` pulse carrying different parameters is injected mid-transaction, and a controller that honoured it would alter the expected line sequence.

// File: rtl/dio_pkg.sv
package dio_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_MODE,
        ST_DUMMY,
        ST_DATA,
        ST_STOP
    } dio_state_e;

    localparam logic [7:0] OP_DUAL_RD   = 8'hBB;
    localparam logic [7:0] OP_DUAL_RD4  = 8'hBC;
    localparam logic [7:0] MODE_KEEP    = 8'hA0;
    localparam logic [7:0] MODE_RELEASE = 8'h00;
endpackage

// File: rtl/dio_txshift.sv
module dio_txshift #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         sh1,
    input  logic         sh2,
    output logic [1:0]   top
);
    logic [W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (sh2) begin
            q <= {q[W-3:0], 2'b00};
        end else if (sh1) begin
            q <= {q[W-2:0], 1'b0};
        end
    end

    assign top = q[W-1:W-2];

    // R3
    shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh1 && sh2));
endmodule

// File: rtl/dio_rxpack.sv
module dio_rxpack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic       last,
    input  logic [1:0] pair,
    output logic [7:0] byte_o,
    output logic       valid_o
);
    logic [5:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            byte_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= sample && last;
            if (sample) begin
                acc <= {acc[3:0], pair};
                if (last) begin
                    byte_o <= {acc, pair};
                end
            end
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

// File: rtl/dio_addrgen.sv
module dio_addrgen #(
    parameter int AW       = 32,
    parameter int SHORT_AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          four,
    input  logic [AW-1:0] start_addr,
    input  logic          inc,
    output logic [AW-1:0] byte_addr
);
    logic [AW-1:0] cur;
    logic          four_q;
    logic [AW-1:0] nxt;

    always_comb begin
        if (four_q) begin
            nxt = cur + 1'b1;
        end else begin
            nxt = {{(AW-SHORT_AW){1'b0}}, cur[SHORT_AW-1:0] + 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur       <= '0;
            four_q    <= 1'b0;
            byte_addr <= '0;
        end else if (load) begin
            four_q <= four;
            cur    <= four ? start_addr
                           : {{(AW-SHORT_AW){1'b0}}, start_addr[SHORT_AW-1:0]};
        end else if (inc) begin
            byte_addr <= cur;
            cur       <= nxt;
        end
    end

    // R8
    short_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && !four_q && (cur[SHORT_AW-1:0] == {SHORT_AW{1'b1}}))
        |=> (cur == '0));
endmodule

// File: rtl/dio_read_ctrl.sv
module dio_read_ctrl
    import dio_pkg::*;
#(
    parameter int NB_W  = 16,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      addr,
    input  logic             addr4,
    input  logic             op_sel,
    input  logic [LAT_W-1:0] lat,
    input  logic [NB_W-1:0]  nbytes,
    input  logic             keep_cont,
    input  logic [1:0]       io_in,
    output logic             cs_n,
    output logic             sck,
    output logic [1:0]       io_out,
    output logic [1:0]       io_oe,
    output logic [7:0]       rd_data,
    output logic [31:0]      rd_addr,
    output logic             rd_valid,
    output logic             busy,
    output logic             done
);
    localparam int CW    = NB_W + 2;
    localparam int TX_W  = 48;
    localparam logic [CW-1:0] CMD_SLOTS   = CW'(8);
    localparam logic [CW-1:0] ADDR3_SLOTS = CW'(12);
    localparam logic [CW-1:0] ADDR4_SLOTS = CW'(16);
    localparam logic [CW-1:0] MODE_SLOTS  = CW'(4);

    dio_state_e       state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             ph_q;
    logic             cont_q;
    logic             keep_q;
    logic [LAT_W-1:0] lat_q;
    logic [NB_W-1:0]  nb_q;

    logic             launch, slot_end, sample, last_pair;
    logic             four;
    logic [7:0]       opcode, mode_byte;
    logic [TX_W-1:0]  frame_full, frame_load;
    logic [1:0]       tx_top;
    logic [CW-1:0]    lat_slots, data_slots;

    assign launch     = (state_q == ST_IDLE) && start;
    assign slot_end   = ph_q && (cnt_q == CW'(1));
    assign sample     = (state_q == ST_DATA) && !ph_q;
    assign last_pair  = (cnt_q[1:0] == 2'd1);
    assign four       = op_sel || addr4;
    assign opcode     = op_sel ? OP_DUAL_RD4 : OP_DUAL_RD;
    assign mode_byte  = keep_cont ? MODE_KEEP : MODE_RELEASE;
    assign lat_slots  = {{(CW-LAT_W){1'b0}}, lat_q};
    assign data_slots = {nb_q, 2'b00};

    always_comb begin
        if (four) begin
            frame_full = {opcode, addr, mode_byte};
        end else begin
            frame_full = {opcode, addr[23:0], mode_byte, 8'h00};
        end
        frame_load = cont_q ? {frame_full[TX_W-9:0], 8'h00} : frame_full;
    end

    // next state and slot count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (cont_q) begin
                        state_d = ST_ADDR;
                        cnt_d   = four ? ADDR4_SLOTS : ADDR3_SLOTS;
                    end else begin
                        state_d = ST_CMD;
                        cnt_d   = CMD_SLOTS;
                    end
                end
            end
            ST_CMD: begin
                if (slot_end) begin
                    state_d = ST_ADDR;
                    cnt_d   = (op_sel_q || addr4_q) ? ADDR4_SLOTS : ADDR3_SLOTS;
                end else if (ph_q) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_ADDR: begin
                if (slot_end) begin
                    state_d = ST_MODE;
                    cnt_d   = MODE_SLOTS;
                end else if (ph_q) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_MODE: begin
                if (slot_end) begin
                    if (lat_q != '0) begin
                        state_d = ST_DUMMY;
                        cnt_d   = lat_slots;
                    end else if (nb_q != '0) begin
                        state_d = ST_DATA;
                        cnt_d   = data_slots;
                    end else begin
                        state_d = ST_STOP;
                        cnt_d   = '0;
                    end
                end else if (ph_q) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_DUMMY: begin
                if (slot_end) begin
                    if (nb_q != '0) begin
                        state_d = ST_DATA;
                        cnt_d   = data_slots;
                    end else begin
                        state_d = ST_STOP;
                        cnt_d   = '0;
                    end
                end else if (ph_q) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_DATA: begin
                if (slot_end) begin
                    state_d = ST_STOP;
                    cnt_d   = '0;
                end else if (ph_q) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_STOP: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    logic op_sel_q, addr4_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            ph_q     <= 1'b0;
            cont_q   <= 1'b0;
            keep_q   <= 1'b0;
            lat_q    <= '0;
            nb_q     <= '0;
            op_sel_q <= 1'b0;
            addr4_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_IDLE || state_q == ST_STOP) begin
                ph_q <= 1'b0;
            end else begin
                ph_q <= !ph_q;
            end
            if (launch) begin
                keep_q   <= keep_cont;
                lat_q    <= lat;
                nb_q     <= nbytes;
                op_sel_q <= op_sel;
                addr4_q  <= addr4;
            end
            if (state_q == ST_MODE && slot_end) begin
                cont_q <= keep_q;
            end
        end
    end

    // outputs
    always_comb begin
        cs_n   = 1'b0;
        sck    = ph_q;
        io_oe  = 2'b00;
        io_out = 2'b00;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cs_n = 1'b1;
                sck  = 1'b0;
                busy = 1'b0;
            end
            ST_CMD: begin
                io_oe  = 2'b01;
                io_out = {1'b0, tx_top[1]};
            end
            ST_ADDR, ST_MODE: begin
                io_oe  = 2'b11;
                io_out = tx_top;
            end
            ST_DUMMY, ST_DATA: begin
                io_oe = 2'b00;
            end
            ST_STOP: begin
                cs_n = 1'b1;
                sck  = 1'b0;
                done = 1'b1;
            end
            default: begin
                cs_n = 1'b1;
                sck  = 1'b0;
            end
        endcase
    end

    dio_txshift #(.W(TX_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (frame_load),
        .sh1      ((state_q == ST_CMD) && ph_q),
        .sh2      (((state_q == ST_ADDR) || (state_q == ST_MODE)) && ph_q),
        .top      (tx_top)
    );

    dio_rxpack u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .last    (last_pair),
        .pair    (io_in),
        .byte_o  (rd_data),
        .valid_o (rd_valid)
    );

    dio_addrgen #(.AW(32), .SHORT_AW(24)) u_ag (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (launch),
        .four       (four),
        .start_addr (addr),
        .inc        (sample && last_pair),
        .byte_addr  (rd_addr)
    );

    // R9
    sck_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    // R7
    valid_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (sck && !cs_n));

    // R5
    cmd_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && cont_q) |=> (state_q == ST_ADDR));

    // R6
    release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 2'b00 && !cs_n) |=> (io_oe == 2'b00 || cs_n));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);
endmodule

// File: tb/sim_dio_read_ctrl.sv
module sim_dio_read_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] addr = '0;
    logic        addr4 = 1'b0;
    logic        op_sel = 1'b0;
    logic [3:0]  lat = '0;
    logic [15:0] nbytes = '0;
    logic        keep_cont = 1'b0;
    logic [1:0]  io_in = '0;
    logic        cs_n, sck, rd_valid, busy, done;
    logic [1:0]  io_out, io_oe;
    logic [7:0]  rd_data;
    logic [31:0] rd_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit cont_model = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dio_read_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .addr4(addr4),
        .op_sel(op_sel), .lat(lat), .nbytes(nbytes), .keep_cont(keep_cont),
        .io_in(io_in), .cs_n(cs_n), .sck(sck), .io_out(io_out), .io_oe(io_oe),
        .rd_data(rd_data), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .busy(busy), .done(done)
    );

    function automatic logic [7:0] flash_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] byte_addr(input logic [31:0] a0, input bit four, input int k);
        logic [31:0] r;
        if (four) r = a0 + 32'(k);
        else r = {8'h00, a0[23:0] + 24'(k)};
        return r;
    endfunction

    task automatic run_txn(input bit t_op, input bit t_a4, input logic [31:0] t_addr,
                           input int t_lat, input int t_nb, input bit t_keep,
                           input bit interject);
        bit four = t_op || t_a4;
        int cmd_s = cont_model ? 0 : 8;
        int adr_s = four ? 16 : 12;
        int abits = four ? 32 : 24;
        logic [7:0] op = t_op ? 8'hBC : 8'hBB;
        logic [7:0] md = t_keep ? 8'hA0 : 8'h00;
        logic [31:0] a0 = four ? t_addr : {8'h00, t_addr[23:0]};
        int base_d = cmd_s + adr_s + 4 + t_lat;
        int total = base_d + 4 * t_nb;
        @(negedge clk);
        op_sel = t_op; addr4 = t_a4; addr = t_addr; lat = 4'(t_lat);
        nbytes = 16'(t_nb); keep_cont = t_keep; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c <= 2 * total + 1; c++) begin
            logic e_cs, e_sck, e_valid, e_busy, e_done;
            logic [1:0] e_oe, e_out;
            logic [7:0] e_data;
            logic [31:0] e_addr;
            string rq;
            int s = c / 2;
            int h = c % 2;
            e_cs = 1'b1; e_sck = 1'b0; e_oe = 2'b00; e_out = 2'b00;
            e_valid = 1'b0; e_busy = 1'b1; e_done = 1'b0;
            e_data = '0; e_addr = '0; rq = "R9";
            if (c < 2 * total) begin
                e_cs = 1'b0; e_sck = h[0];
                if (s < cmd_s) begin
                    rq = "R2"; e_oe = 2'b01; e_out = {1'b0, op[7 - s]};
                end else if (s < cmd_s + adr_s) begin
                    int i = s - cmd_s;
                    rq = cont_model ? "R5/R3" : "R3";
                    e_oe = 2'b11; e_out = 2'((a0 >> (abits - 2 - 2 * i)) & 3);
                end else if (s < cmd_s + adr_s + 4) begin
                    int j = s - cmd_s - adr_s;
                    rq = "R4"; e_oe = 2'b11; e_out = 2'((md >> (6 - 2 * j)) & 3);
                end else if (s < base_d) begin
                    rq = "R6";
                end else begin
                    int d = s - base_d;
                    logic [31:0] ba = byte_addr(a0, four, d / 4);
                    logic [7:0] fb = flash_byte(ba);
                    rq = "R7/R8";
                    if (h == 0) io_in = 2'((fb >> (6 - 2 * (d % 4))) & 3);
                    if (h == 1 && d % 4 == 3) begin
                        e_valid = 1'b1; e_data = fb; e_addr = ba;
                    end
                end
            end else if (c == 2 * total) begin
                rq = "R10"; e_done = 1'b1;
            end else begin
                rq = "R10"; e_busy = 1'b0;
            end
            if (interject) begin
                if (c == 10) begin
                    start = 1'b1; addr = ~t_addr; op_sel = ~t_op; lat = 4'd1;
                    nbytes = 16'd7; keep_cont = ~t_keep;
                end else begin
                    start = 1'b0;
                end
                if (c >= 10) rq = {rq, "/R11"};
            end
            n_cmp++;
            if (cs_n !== e_cs || sck !== e_sck || io_oe !== e_oe ||
                (io_out & e_oe) !== (e_out & e_oe) || rd_valid !== e_valid ||
                busy !== e_busy || done !== e_done ||
                (e_valid && (rd_data !== e_data || rd_addr !== e_addr))) begin
                n_bad++;
                $display("FAIL %s cycle %0d: got cs_n=%b sck=%b oe=%b out=%b v=%b d=%h a=%h busy=%b done=%b exp cs_n=%b sck=%b oe=%b out=%b v=%b d=%h a=%h busy=%b done=%b",
                         rq, c, cs_n, sck, io_oe, io_out, rd_valid, rd_data, rd_addr, busy, done,
                         e_cs, e_sck, e_oe, e_out, e_valid, e_data, e_addr, e_busy, e_done);
            end
            @(negedge clk);
        end
        cont_model = t_keep;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_bad++;
                $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        n_cmp++;
        if (cs_n !== 1'b1 || sck !== 1'b0 || io_oe !== 2'b00 || busy !== 1'b0 ||
            done !== 1'b0 || rd_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got cs_n=%b sck=%b oe=%b busy=%b done=%b v=%b expected 1 0 00 0 0 0",
                     cs_n, sck, io_oe, busy, done, rd_valid);
        end
        // R2 R3 R4 R8: first read sends instruction, 3-byte wrap, latency 4
        run_txn(1'b0, 1'b0, 32'h77FF_FFFE, 4, 4, 1'b1, 1'b0);
        // R5 R6: continued read skips instruction, zero latency
        run_txn(1'b0, 1'b0, 32'h0012_3456, 0, 2, 1'b0, 1'b0);
        // R5 R8: instruction again after 00h, 4-byte wrap
        run_txn(1'b0, 1'b1, 32'hFFFF_FFFF, 2, 2, 1'b1, 1'b0);
        // R5 R10: continued BCh read, no bytes
        run_txn(1'b1, 1'b0, 32'h8000_0010, 8, 0, 1'b0, 1'b0);
        // R11 R6: start while busy, maximum latency
        run_txn(1'b1, 1'b0, 32'h0000_01FE, 15, 3, 1'b0, 1'b1);
        // R5: back to back continued reads
        run_txn(1'b0, 1'b0, 32'h00AB_CDEF, 1, 1, 1'b1, 1'b0);
        run_txn(1'b0, 1'b0, 32'h0000_0000, 3, 2, 1'b0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule